// File: doc/BRIEF.md
# Bus Error Capture Unit

This unit sits beside a system bus and watches its transactions one at a time. A transaction fails in one of two ways. The first is that a slave answers with an error acknowledge. The second is that no slave answers at all within a set number of cycles after the address phase. When a transaction fails, the unit records a snapshot of it: the address, the 64-bit data bus contents (split into a low word and a high word), and an attribute word. The attribute word holds the kind of failure, the direction, the transfer size, the requesting master and a valid flag.

Only the first failure is kept. After a capture, the snapshot is frozen and later failures are dropped until software writes a release. Each capture produces a one-cycle service request pulse. That pulse is passed on as an interrupt pulse only when the interrupt enable is set. Software reads the snapshot, and writes the control word, through a small word-wide register port with combinational read data.

The unit holds two state machines.

The watcher has two states, W_IDLE and W_WAIT:
- W_IDLE to W_WAIT: an address phase is seen.
- W_WAIT to W_IDLE: the transaction ends. It ends on a good response, on an error acknowledge, or when the timeout expires.
- W_WAIT to W_WAIT with a fresh transaction: a new address phase arrives in the same cycle the current transaction ends.

The lock has two states, L_ARMED and L_LOCKED:
- L_ARMED to L_LOCKED: a failure event occurs.
- L_LOCKED to L_ARMED: a release is written.
- L_LOCKED stays in L_LOCKED with a new capture: a release and a failure event occur in the same cycle.

Top module: `bus_err_capture`

## Requirements
- R1: A slave error acknowledge (mon_err_ack) that arrives 1 to TIMEOUT cycles after the address phase causes a capture with error type 1. If ready and error acknowledge arrive together, the error wins.
- R2: A good response (mon_ready without mon_err_ack) within 1 to TIMEOUT cycles ends the transaction with no capture. No response within TIMEOUT cycles causes a capture with error type 0.
- R3: On capture, register select 1 reads the failing transaction's address.
- R4: On capture, register select 2 reads data bus bits 31:0 and select 3 reads bits 63:32. Both are sampled in the cycle the transaction ends, which is the response cycle or the timeout cycle.
- R5: Register select 4 reads the attribute word. Bit 0 is the valid flag, bit 1 the error type, bit 2 the write flag, bits 4:3 the size and bits 11:8 the master ID.
- R6: While captured, later failures change no register and raise no service request.
- R7: Writing control (select 0) with bit 0 set clears the valid flag and re-arms capture from the next cycle. A failure in the same cycle as the release write is captured.
- R8: srq is a one-cycle pulse in the cycle after each capture.
- R9: irq pulses together with srq only when control bit 1 (interrupt enable) is set. Control reads back bit 1, and bit 0 reads as 0.
- R10: After reset, all registers read 0, srq and irq are 0, and capture is armed.
- R11: Ready or error acknowledge with no transaction being watched is ignored. The watcher handles one transaction at a time, and an address phase inside an open window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_addr_valid | input | 1 | Address phase completes this cycle |
| mon_addr | input | AW | Transaction address |
| mon_write | input | 1 | 1 = write transfer |
| mon_size | input | SW | Transfer size code |
| mon_master | input | MW | Requesting master ID |
| mon_ready | input | 1 | Slave responded without error |
| mon_err_ack | input | 1 | Slave responded with error acknowledge |
| mon_data | input | DW | Data bus contents |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data, combinational |
| srq | output | 1 | Service request pulse |
| irq | output | 1 | Interrupt pulse, gated by enable |

## Verification
The bench sweeps three response kinds: good ready, error acknowledge and silence. Each kind is tried at every response delay from 1 to TIMEOUT+1 and for both directions. The sweep separates an in-window response from an expired window, and an error acknowledge from a timeout, by the type bit and by whether srq fires. The interrupt enable alternates across the sweep, which separates srq from irq. Further patterns cover these cases:
- Errors that arrive while captured, which must leave the snapshot untouched.
- A release written in the same cycle as an error acknowledge.
- Stray responses with no open transaction.

// File: rtl/bec_pkg.sv
package bec_pkg;

    typedef enum logic {
        W_IDLE = 1'b0,
        W_WAIT = 1'b1
    } watch_state_e;

    typedef enum logic {
        L_ARMED  = 1'b0,
        L_LOCKED = 1'b1
    } lock_state_e;

    localparam logic ETYPE_NOSLAVE = 1'b0;
    localparam logic ETYPE_ERRACK  = 1'b1;

    localparam logic [2:0] RSEL_CTRL = 3'd0;
    localparam logic [2:0] RSEL_ADDR = 3'd1;
    localparam logic [2:0] RSEL_DLO  = 3'd2;
    localparam logic [2:0] RSEL_DHI  = 3'd3;
    localparam logic [2:0] RSEL_ATTR = 3'd4;

    localparam int CTRL_RELEASE_BIT = 0;
    localparam int CTRL_IRQEN_BIT   = 1;

    localparam int ATTR_VALID_BIT = 0;
    localparam int ATTR_TYPE_BIT  = 1;
    localparam int ATTR_WRITE_BIT = 2;
    localparam int ATTR_SIZE_LSB  = 3;
    localparam int ATTR_MST_LSB   = 8;

endpackage

// File: rtl/bec_watch.sv
module bec_watch
    import bec_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MW      = 4,
    parameter int SW      = 2,
    parameter int DW      = 64,
    parameter int TIMEOUT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_valid,
    input  logic [AW-1:0] a_addr,
    input  logic          a_write,
    input  logic [SW-1:0] a_size,
    input  logic [MW-1:0] a_master,
    input  logic          rsp_ready,
    input  logic          rsp_err,
    input  logic [DW-1:0] bus_data,
    output logic          evt,
    output logic          evt_type,
    output logic [AW-1:0] evt_addr,
    output logic          evt_write,
    output logic [SW-1:0] evt_size,
    output logic [MW-1:0] evt_master,
    output logic [DW-1:0] evt_data
);

    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    watch_state_e  st, st_n;
    logic [CW-1:0] cnt;
    logic          ok_hit, err_hit, to_hit, ended;

    always_comb begin
        ok_hit  = (st == W_WAIT) && rsp_ready && !rsp_err;
        err_hit = (st == W_WAIT) && rsp_err;
        to_hit  = (st == W_WAIT) && !rsp_ready && !rsp_err && (cnt == LAST);
        ended   = (st == W_IDLE) || ok_hit || err_hit || to_hit;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            W_IDLE: st_n = a_valid ? W_WAIT : W_IDLE;
            W_WAIT: if (ok_hit || err_hit || to_hit) st_n = a_valid ? W_WAIT : W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= W_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            evt_addr   <= '0;
            evt_write  <= 1'b0;
            evt_size   <= '0;
            evt_master <= '0;
        end else if (ended && a_valid) begin
            cnt        <= '0;
            evt_addr   <= a_addr;
            evt_write  <= a_write;
            evt_size   <= a_size;
            evt_master <= a_master;
        end else if (st == W_WAIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        evt      = err_hit || to_hit;
        evt_type = err_hit ? ETYPE_ERRACK : ETYPE_NOSLAVE;
        evt_data = bus_data;
    end

    p_errack_type_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_WAIT && rsp_err) |-> (evt && evt_type == ETYPE_ERRACK));

    p_good_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_WAIT && rsp_ready && !rsp_err) |-> !evt);

    p_window_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_WAIT) |-> (cnt < CW'(TIMEOUT)));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == W_IDLE) |-> !evt);

endmodule

// File: rtl/bec_lock.sv
module bec_lock
    import bec_pkg::*;
#(
    parameter int AW = 32,
    parameter int MW = 4,
    parameter int SW = 2,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic          evt_type,
    input  logic [AW-1:0] evt_addr,
    input  logic          evt_write,
    input  logic [SW-1:0] evt_size,
    input  logic [MW-1:0] evt_master,
    input  logic [DW-1:0] evt_data,
    input  logic          release_req,
    input  logic          irq_en,
    output logic          cap_valid,
    output logic          cap_type,
    output logic [AW-1:0] cap_addr,
    output logic          cap_write,
    output logic [SW-1:0] cap_size,
    output logic [MW-1:0] cap_master,
    output logic [DW-1:0] cap_data,
    output logic          srq,
    output logic          irq
);

    lock_state_e st, st_n;
    logic        capture_en;

    assign capture_en = evt && ((st == L_ARMED) || release_req);

    always_comb begin
        st_n = st;
        unique case (st)
            L_ARMED:  st_n = capture_en ? L_LOCKED : L_ARMED;
            L_LOCKED: st_n = capture_en ? L_LOCKED : (release_req ? L_ARMED : L_LOCKED);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= L_ARMED;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srq        <= 1'b0;
            irq        <= 1'b0;
            cap_type   <= 1'b0;
            cap_addr   <= '0;
            cap_write  <= 1'b0;
            cap_size   <= '0;
            cap_master <= '0;
            cap_data   <= '0;
        end else begin
            srq <= capture_en;
            irq <= capture_en && irq_en;
            if (capture_en) begin
                cap_type   <= evt_type;
                cap_addr   <= evt_addr;
                cap_write  <= evt_write;
                cap_size   <= evt_size;
                cap_master <= evt_master;
                cap_data   <= evt_data;
            end
        end
    end

    assign cap_valid = (st == L_LOCKED);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == L_LOCKED && !release_req) |=> ($stable(cap_addr) && $stable(cap_data) && !srq));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == L_LOCKED && release_req && !evt) |=> !cap_valid);

    p_srq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> (srq && cap_valid));

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> srq);

endmodule

// File: rtl/bec_regs.sv
module bec_regs
    import bec_pkg::*;
#(
    parameter int AW = 32,
    parameter int MW = 4,
    parameter int SW = 2,
    parameter int DW = 64,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    reg_sel,
    input  logic          reg_wr,
    input  logic [RW-1:0] reg_wdata,
    input  logic          cap_valid,
    input  logic          cap_type,
    input  logic [AW-1:0] cap_addr,
    input  logic          cap_write,
    input  logic [SW-1:0] cap_size,
    input  logic [MW-1:0] cap_master,
    input  logic [DW-1:0] cap_data,
    output logic          release_req,
    output logic          irq_en,
    output logic [RW-1:0] reg_rdata
);

    localparam int HW = DW / 2;

    logic          ctrl_wr;
    logic [RW-1:0] attr_word;
    logic          unused_wbits;

    assign ctrl_wr      = reg_wr && (reg_sel == RSEL_CTRL);
    assign release_req  = ctrl_wr && reg_wdata[CTRL_RELEASE_BIT];
    assign unused_wbits = ^reg_wdata[RW-1:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       irq_en <= 1'b0;
        else if (ctrl_wr) irq_en <= reg_wdata[CTRL_IRQEN_BIT];
    end

    always_comb begin
        attr_word                          = '0;
        attr_word[ATTR_VALID_BIT]          = cap_valid;
        attr_word[ATTR_TYPE_BIT]           = cap_type;
        attr_word[ATTR_WRITE_BIT]          = cap_write;
        attr_word[ATTR_SIZE_LSB +: SW]     = cap_size;
        attr_word[ATTR_MST_LSB +: MW]      = cap_master;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            RSEL_CTRL: reg_rdata[CTRL_IRQEN_BIT] = irq_en;
            RSEL_ADDR: reg_rdata = RW'(cap_addr);
            RSEL_DLO:  reg_rdata = RW'(cap_data[HW-1:0]);
            RSEL_DHI:  reg_rdata = RW'(cap_data[DW-1:HW]);
            RSEL_ATTR: reg_rdata = attr_word;
            default:   reg_rdata = '0;
        endcase
    end

    p_ctrl_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == RSEL_CTRL) |-> (reg_rdata[CTRL_RELEASE_BIT] == 1'b0));

endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
    import bec_pkg::*;
#(
    parameter int AW      = 32,
    parameter int MW      = 4,
    parameter int SW      = 2,
    parameter int DW      = 64,
    parameter int RW      = 32,
    parameter int TIMEOUT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mon_addr_valid,
    input  logic [AW-1:0] mon_addr,
    input  logic          mon_write,
    input  logic [SW-1:0] mon_size,
    input  logic [MW-1:0] mon_master,
    input  logic          mon_ready,
    input  logic          mon_err_ack,
    input  logic [DW-1:0] mon_data,
    input  logic [2:0]    reg_sel,
    input  logic          reg_wr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    output logic          srq,
    output logic          irq
);

    logic          evt, evt_type, evt_write;
    logic [AW-1:0] evt_addr;
    logic [SW-1:0] evt_size;
    logic [MW-1:0] evt_master;
    logic [DW-1:0] evt_data;

    logic          cap_valid, cap_type, cap_write;
    logic [AW-1:0] cap_addr;
    logic [SW-1:0] cap_size;
    logic [MW-1:0] cap_master;
    logic [DW-1:0] cap_data;

    logic          release_req, irq_en;

    bec_watch #(.AW(AW), .MW(MW), .SW(SW), .DW(DW), .TIMEOUT(TIMEOUT)) u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_valid    (mon_addr_valid),
        .a_addr     (mon_addr),
        .a_write    (mon_write),
        .a_size     (mon_size),
        .a_master   (mon_master),
        .rsp_ready  (mon_ready),
        .rsp_err    (mon_err_ack),
        .bus_data   (mon_data),
        .evt        (evt),
        .evt_type   (evt_type),
        .evt_addr   (evt_addr),
        .evt_write  (evt_write),
        .evt_size   (evt_size),
        .evt_master (evt_master),
        .evt_data   (evt_data)
    );

    bec_lock #(.AW(AW), .MW(MW), .SW(SW), .DW(DW)) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .evt_type    (evt_type),
        .evt_addr    (evt_addr),
        .evt_write   (evt_write),
        .evt_size    (evt_size),
        .evt_master  (evt_master),
        .evt_data    (evt_data),
        .release_req (release_req),
        .irq_en      (irq_en),
        .cap_valid   (cap_valid),
        .cap_type    (cap_type),
        .cap_addr    (cap_addr),
        .cap_write   (cap_write),
        .cap_size    (cap_size),
        .cap_master  (cap_master),
        .cap_data    (cap_data),
        .srq         (srq),
        .irq         (irq)
    );

    bec_regs #(.AW(AW), .MW(MW), .SW(SW), .DW(DW), .RW(RW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_sel     (reg_sel),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .cap_valid   (cap_valid),
        .cap_type    (cap_type),
        .cap_addr    (cap_addr),
        .cap_write   (cap_write),
        .cap_size    (cap_size),
        .cap_master  (cap_master),
        .cap_data    (cap_data),
        .release_req (release_req),
        .irq_en      (irq_en),
        .reg_rdata   (reg_rdata)
    );

endmodule

// File: tb/bus_err_capture_tb.sv
module bus_err_capture_tb;

    localparam int T = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mon_addr_valid = 1'b0;
    logic [31:0] mon_addr = '0;
    logic        mon_write = 1'b0;
    logic [1:0]  mon_size = '0;
    logic [3:0]  mon_master = '0;
    logic        mon_ready = 1'b0;
    logic        mon_err_ack = 1'b0;
    logic [63:0] mon_data = '0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        srq, irq;

    int checks = 0;
    int errors = 0;
    int srq_cnt = 0;
    int irq_cnt = 0;
    logic en_cur = 1'b0;

    always #5 clk = ~clk;

    bus_err_capture #(.TIMEOUT(T)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .mon_addr_valid(mon_addr_valid), .mon_addr(mon_addr), .mon_write(mon_write),
        .mon_size(mon_size), .mon_master(mon_master), .mon_ready(mon_ready),
        .mon_err_ack(mon_err_ack), .mon_data(mon_data),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .srq(srq), .irq(irq)
    );

    always @(posedge clk) begin
        if (srq) srq_cnt <= srq_cnt + 1;
        if (irq) irq_cnt <= irq_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] v);
        @(negedge clk);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic wr_ctrl(input logic rel, input logic en);
        @(negedge clk);
        reg_sel = 3'd0; reg_wdata = {30'd0, en, rel}; reg_wr = 1'b1;
        en_cur = en;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // kind: 0 good ready, 1 error acknowledge, 2 silence
    task automatic txn(input logic [31:0] a, input logic w, input logic [1:0] sz,
                       input logic [3:0] m, input logic [63:0] d, input int kind,
                       input int dly, input bit rel);
        @(negedge clk);
        mon_addr_valid = 1'b1; mon_addr = a; mon_write = w; mon_size = sz;
        mon_master = m; mon_data = d;
        @(negedge clk);
        mon_addr_valid = 1'b0;
        repeat (dly - 1) @(negedge clk);
        if (kind == 0) mon_ready = 1'b1;
        if (kind == 1) mon_err_ack = 1'b1;
        if (rel) begin
            reg_sel = 3'd0; reg_wdata = {30'd0, en_cur, 1'b1}; reg_wr = 1'b1;
        end
        @(negedge clk);
        mon_ready = 1'b0; mon_err_ack = 1'b0; reg_wr = 1'b0;
        repeat (T + 2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        logic [31:0] last_a;
        int s0, i0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        for (int s = 0; s < 5; s++) begin
            rd(3'(s), v);
            check(v == 32'd0, "R10 reset register", 64'(v), 64'd0);
        end
        check(srq == 1'b0 && irq == 1'b0, "R10 reset srq/irq", {62'd0, srq, irq}, 64'd0);

        // R11 stray responses while idle
        @(negedge clk); mon_err_ack = 1'b1; mon_ready = 1'b1;
        @(negedge clk); mon_err_ack = 1'b0; mon_ready = 1'b0;
        repeat (2) @(negedge clk);
        rd(3'd4, v);
        check(v[0] == 1'b0, "R11 stray response ignored (valid)", 64'(v[0]), 64'd0);
        check(srq_cnt == 0, "R11 stray response ignored (srq)", 64'(srq_cnt), 64'd0);

        // Main sweep: R1 R2 R3 R4 R5 R8 R9
        for (int k = 0; k < 3; k++) begin
            for (int dl = 1; dl <= T + 1; dl++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [31:0] a;
                    logic [63:0] dd;
                    logic [3:0]  m;
                    logic [1:0]  sz;
                    logic        en, is_err, ty;
                    a  = 32'h1000_0000 + 32'(k * 256 + dl * 16 + w);
                    dd = {a ^ 32'hA5A5_0000, ~a};
                    m  = 4'((k * 5 + dl + w) % 16);
                    sz = 2'(dl % 4);
                    en = 1'((dl + w) % 2);
                    is_err = (kind_err(k, dl));
                    ty = (k == 1 && dl <= T);
                    wr_ctrl(1'b1, en);
                    s0 = srq_cnt; i0 = irq_cnt;
                    txn(a, 1'(w), sz, m, dd, k, dl, 1'b0);
                    rd(3'd4, v);
                    if (is_err) begin
                        logic [31:0] ea;
                        ea = {20'd0, m, 3'd0, sz, 1'(w), ty, 1'b1};
                        check(v == ea, "R5 R1 R2 attribute word", 64'(v), 64'(ea));
                        rd(3'd1, v);
                        check(v == a, "R3 captured address", 64'(v), 64'(a));
                        rd(3'd2, v);
                        rd(3'd3, v2);
                        check({v2, v} == dd, "R4 captured data halves", {v2, v}, dd);
                        check(srq_cnt == s0 + 1, "R8 one srq pulse per capture", 64'(srq_cnt - s0), 64'd1);
                        check(irq_cnt == i0 + int'(en), "R9 irq gated by enable", 64'(irq_cnt - i0), 64'(en));
                        last_a = a;
                    end else begin
                        check(v[0] == 1'b0, "R2 good response not captured", 64'(v[0]), 64'd0);
                        check(srq_cnt == s0, "R2 no srq on good response", 64'(srq_cnt - s0), 64'd0);
                    end
                    rd(3'd0, v);
                    check(v == {30'd0, en, 1'b0}, "R9 control readback", 64'(v), 64'({en, 1'b0}));
                end
            end
        end

        // R6 lock: last sweep entry captured; further errors dropped
        s0 = srq_cnt;
        txn(32'hDEAD_0000, 1'b1, 2'd3, 4'd9, 64'h1234, 1, 2, 1'b0);
        txn(32'hDEAD_0004, 1'b0, 2'd1, 4'd7, 64'h5678, 2, 1, 1'b0);
        rd(3'd1, v);
        check(v == last_a, "R6 address held while locked", 64'(v), 64'(last_a));
        check(srq_cnt == s0, "R6 no srq while locked", 64'(srq_cnt - s0), 64'd0);

        // R7 release alone clears valid
        wr_ctrl(1'b1, 1'b1);
        rd(3'd4, v);
        check(v[0] == 1'b0, "R7 release clears valid", 64'(v[0]), 64'd0);

        // R7 release in same cycle as error acknowledge
        txn(32'h2000_0040, 1'b0, 2'd2, 4'd3, 64'hAAAA_BBBB_CCCC_DDDD, 1, 3, 1'b0);
        s0 = srq_cnt;
        txn(32'h2000_0080, 1'b1, 2'd1, 4'd6, 64'h1111_2222_3333_4444, 1, 2, 1'b1);
        rd(3'd1, v);
        check(v == 32'h2000_0080, "R7 same-cycle release then capture (addr)", 64'(v), 64'h2000_0080);
        rd(3'd4, v);
        check(v == 32'h0000_060F, "R7 same-cycle release then capture (attr)", 64'(v), 64'h60F);
        check(srq_cnt == s0 + 1, "R7 srq on same-cycle capture", 64'(srq_cnt - s0), 64'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic kind_err(input int k, input int dl);
        return (k == 1) || (k == 2) || (dl > T);
    endfunction

endmodule